// File: doc/BRIEF.md
# Full/Empty Token Pipeline Controller

This block is a clock-driven model of a self-timed linear pipeline. A row of data latches is separated by channels. Each channel carries one state bit that does the work of both request and acknowledge: a low level means the channel holds an item, and a high level means it is vacant. Every stage controller watches the channel on its input side and the channel on its output side. When the input side is full and the output side is vacant, the controller fires. Firing opens its latch for a single capture, turns the input channel vacant and, one cycle later, turns the output channel full. The whole row then acts as an elastic FIFO.

Items advance at two clock cycles per stage. A vacancy (hole) ripples backward at one cycle per stage, so holes travel at twice the speed of items. Writers present a word with a valid/accept pair. Readers see the head word with a valid/take pair. The number of stages and the word width are parameters.

Top module: `fe_pipe`

## Requirements
- R1: After reset every channel is vacant: `wr_ready` is 1 and `rd_valid` is 0.
- R2: A write is taken only on a clock edge where `wr_valid` and `wr_ready` are both 1. `wr_ready` is 1 exactly when the first channel is vacant, and it drops on the edge that accepts a word.
- R3: Words come out on `rd_data` in the order they were accepted, unchanged. None is lost or duplicated.
- R4: In an idle, empty pipeline, a word accepted at edge w raises `rd_valid` at edge w + 2·STAGES and not before. Each channel becomes full exactly two cycles after its upstream stage fired.
- R5: In a completely full pipeline, a take at edge r raises `wr_ready` at edge r + STAGES and not before. Each channel becomes vacant exactly one cycle after the stage reading it fired, or after a take for the last channel.
- R6: With reads stalled, the pipeline accepts exactly STAGES + 1 words. Occupancy never exceeds that.
- R7: While `rd_valid` is 1 and `rd_take` is 0, `rd_valid` stays 1 and `rd_data` holds its value on the next cycle.
- R8: No channel state bit is told to go full and vacant in the same cycle. Firing decisions use only the registered channel states.
- R9: A fired stage leaves its input channel vacant and its output channel still vacant on the next cycle. It completes the move one cycle later. The state bit is 0 for full and 1 for vacant.
- R10: `rd_take` while `rd_valid` is 0, and `wr_valid` while `wr_ready` is 0, change nothing. No word is consumed or inserted, and the ready/valid outputs are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Write word offered |
| wr_data | input | DW | Word to write |
| wr_ready | output | 1 | First channel vacant; write will be accepted |
| rd_valid | output | 1 | Last channel full; head word present |
| rd_data | output | DW | Head word |
| rd_take | input | 1 | Consume the head word |

## Verification
The bench builds the block with STAGES = 3 and DW = 16. Three stages are enough to show the 6-cycle item latency against the 3-cycle hole latency. The four-word capacity is filled in a few cycles. The 16-bit width lets random words make a duplicated or stale output visible. The random phases switch between write-heavy, read-heavy and balanced traffic. This drives the pipeline through full, empty and partly filled states where neighbouring stages fire in adjacent cycles.

// File: rtl/fe_pipe_pkg.sv
package fe_pipe_pkg;
  // Channel state encoding: one bit carries request and acknowledge together.
  localparam logic CH_FULL  = 1'b0;
  localparam logic CH_EMPTY = 1'b1;

  // Stage controller phase: idle, or midway through forwarding an item.
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_MOVE = 1'b1
  } stage_ph_e;
endpackage

// File: rtl/fe_chan_state.sv
module fe_chan_state
  import fe_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mark_full,
  input  logic mark_empty,
  output logic st
);
  // One shared state bit per channel; vacant out of reset.
  always_ff @(posedge clk) begin
    if (rst) begin
      st <= CH_EMPTY;
    end else if (mark_full) begin
      st <= CH_FULL;
    end else if (mark_empty) begin
      st <= CH_EMPTY;
    end
  end
endmodule

// File: rtl/fe_stage_ctl.sv
module fe_stage_ctl
  import fe_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic in_st,
  input  logic out_st,
  output logic fire,
  output logic deliver
);
  stage_ph_e ph_q;

  // Decision from registered channel states only: input full, output vacant.
  always_comb begin
    fire    = (ph_q == PH_IDLE) && (in_st == CH_FULL) && (out_st == CH_EMPTY);
    deliver = (ph_q == PH_MOVE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
    end else begin
      case (ph_q)
        PH_IDLE: if (fire) ph_q <= PH_MOVE;
        PH_MOVE: ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fe_data_latch.sv
module fe_data_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          en,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  // Data path carries no reset; validity lives in the channel state bits.
  always_ff @(posedge clk) begin
    if (en) q <= d;
  end
endmodule

// File: rtl/fe_pipe.sv
module fe_pipe
  import fe_pipe_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int DW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  output logic          wr_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  input  logic          rd_take
);
  localparam int NCH = STAGES + 1;

  logic [NCH-1:0]         ch_st;
  logic [NCH-1:0]         set_full;
  logic [NCH-1:0]         set_empty;
  logic [STAGES-1:0]      fire;
  logic [STAGES-1:0]      deliver;
  logic [NCH-1:0]         lat_en;
  logic [NCH-1:0][DW-1:0] lat_d;
  logic [NCH-1:0][DW-1:0] lat_q;

  // Stage controllers sit between channel k and channel k+1.
  for (genvar k = 0; k < STAGES; k++) begin : g_stage
    fe_stage_ctl u_ctl (
      .clk    (clk),
      .rst    (rst),
      .in_st  (ch_st[k]),
      .out_st (ch_st[k+1]),
      .fire   (fire[k]),
      .deliver(deliver[k])
    );
  end

  // Channel state bits and the latch that holds each channel's item.
  for (genvar c = 0; c < NCH; c++) begin : g_chan
    if (c == 0) begin : g_head
      always_comb begin
        set_full[c]  = wr_valid && (ch_st[c] == CH_EMPTY);
        set_empty[c] = fire[c];
        lat_en[c]    = set_full[c];
        lat_d[c]     = wr_data;
      end
    end else if (c == NCH - 1) begin : g_tail
      always_comb begin
        set_full[c]  = deliver[c-1];
        set_empty[c] = rd_take && (ch_st[c] == CH_FULL);
        lat_en[c]    = fire[c-1];
        lat_d[c]     = lat_q[c-1];
      end
    end else begin : g_mid
      always_comb begin
        set_full[c]  = deliver[c-1];
        set_empty[c] = fire[c];
        lat_en[c]    = fire[c-1];
        lat_d[c]     = lat_q[c-1];
      end
    end

    fe_chan_state u_st (
      .clk       (clk),
      .rst       (rst),
      .mark_full (set_full[c]),
      .mark_empty(set_empty[c]),
      .st        (ch_st[c])
    );

    fe_data_latch #(.DW(DW)) u_lat (
      .clk(clk),
      .en (lat_en[c]),
      .d  (lat_d[c]),
      .q  (lat_q[c])
    );
  end

  // All outputs come straight from registers.
  always_comb begin
    wr_ready = (ch_st[0] == CH_EMPTY);
    rd_valid = (ch_st[STAGES] == CH_FULL);
    rd_data  = lat_q[STAGES];
  end
endmodule

// File: rtl/fe_pipe_chk.sv
module fe_pipe_chk #(
  parameter int STAGES = 4,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic              rd_valid,
  input logic              rd_take,
  input logic [DW-1:0]     rd_data,
  input logic [STAGES:0]   ch_st,
  input logic [STAGES:0]   set_full,
  input logic [STAGES:0]   set_empty,
  input logic [STAGES-1:0] fire
);
  localparam int OW = $clog2(STAGES + 3);
  logic [OW-1:0] occ;

  always_ff @(posedge clk) begin
    if (rst) begin
      occ <= '0;
    end else begin
      case ({wr_valid && wr_ready, rd_valid && rd_take})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  a_r1_reset_state: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wr_ready && !rd_valid));

  a_r2_accept_only: assert property (@(posedge clk) disable iff (rst)
    $fell(ch_st[0]) |-> $past(wr_valid && wr_ready));

  a_r5_tail_vacate: assert property (@(posedge clk) disable iff (rst)
    $rose(ch_st[STAGES]) |-> $past(rd_valid && rd_take));

  a_r6_capacity: assert property (@(posedge clk) disable iff (rst)
    occ <= OW'(STAGES + 1));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_take) |=> (rd_valid && $stable(rd_data)));

  a_r8_one_writer: assert property (@(posedge clk) disable iff (rst)
    (set_full & set_empty) == '0);

  for (genvar k = 0; k < STAGES; k++) begin : g_stage_chk
    a_r4_fill_after_two: assert property (@(posedge clk) disable iff (rst)
      $fell(ch_st[k+1]) |-> $past(fire[k], 2));

    a_r5_hole_one: assert property (@(posedge clk) disable iff (rst)
      $rose(ch_st[k]) |-> $past(fire[k]));

    a_r9_fire_effect: assert property (@(posedge clk) disable iff (rst)
      fire[k] |=> (ch_st[k] && ch_st[k+1]));
  end
endmodule

bind fe_pipe fe_pipe_chk #(.STAGES(STAGES), .DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .rd_valid (rd_valid),
  .rd_take  (rd_take),
  .rd_data  (rd_data),
  .ch_st    (ch_st),
  .set_full (set_full),
  .set_empty(set_empty),
  .fire     (fire)
);

// File: tb/sim_fe_pipe.sv
module sim_fe_pipe;
  localparam int S  = 3;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          rd_take = 1'b0;

  int n_chk  = 0;
  int n_fail = 0;
  int n_acc  = 0;
  bit finished = 1'b0;
  int max_occ = 0;
  logic [DW-1:0] sb[$];

  always #4 clk = ~clk;  // 125 MHz

  fe_pipe #(.STAGES(S), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_take(rd_take)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int hole_edges(input int stages);
    return stages;
  endfunction

  function automatic int item_edges(input int stages);
    return 2 * stages;
  endfunction

  // One clock: apply inputs, log handshakes against the scoreboard, advance.
  task automatic step(input logic wv, input logic [DW-1:0] wd, input logic rt);
    logic [DW-1:0] exp_w;
    wr_valid = wv;
    wr_data  = wd;
    rd_take  = rt;
    #1;
    if (wv && wr_ready) begin
      sb.push_back(wd);
      n_acc++;
    end
    if (rt && rd_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R3", "word out with none pending", rd_data, 0);
      end else begin
        exp_w = sb.pop_front();
        chk(rd_data == exp_w, "R3", "head word order/value", rd_data, exp_w);
      end
    end
    @(posedge clk);
    #1;
    if (sb.size() > max_occ) max_occ = sb.size();
    wr_valid = 1'b0;
    rd_take  = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    if (!finished) begin
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] hold;
    bit seen;
    int acc0;
    void'($urandom(32'h5EED_0F17));

    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    @(posedge clk);
    #1;
    // R1: vacant after reset
    chk(wr_ready == 1'b1, "R1", "wr_ready after reset", wr_ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);

    // R4: forward latency through an empty pipeline
    step(1'b1, 16'hA5C3, 1'b0);
    chk(n_acc == 1, "R2", "write accepted when ready", n_acc, 1);
    chk(wr_ready == 1'b0, "R2", "wr_ready drops on accept", wr_ready, 0);
    seen = 1'b0;
    for (int k = 1; k < item_edges(S); k++) begin
      step(1'b0, '0, 1'b0);
      if (rd_valid) seen = 1'b1;
    end
    chk(!seen, "R4", "rd_valid early", seen, 0);
    step(1'b0, '0, 1'b0);
    chk(rd_valid == 1'b1, "R4", "rd_valid at 2*STAGES", rd_valid, 1);
    chk(rd_data == 16'hA5C3, "R4", "rd_data at arrival", rd_data, 16'hA5C3);
    step(1'b0, '0, 1'b1);
    chk(rd_valid == 1'b0, "R3", "pipeline empty after take", rd_valid, 0);

    // R10: take while nothing is valid has no effect
    repeat (3) step(1'b0, '0, 1'b1);
    chk(rd_valid == 1'b0 && wr_ready == 1'b1, "R10", "idle take changed state",
        {rd_valid, wr_ready}, 2'b01);
    chk(sb.size() == 0, "R10", "scoreboard after idle take", sb.size(), 0);

    // R6 / R7: fill with reads stalled
    n_acc = 0;
    seen = 1'b0;
    hold = '0;
    for (int k = 0; k < 40; k++) begin
      step(1'b1, DW'(16'h1000 + n_acc), 1'b0);
      if (rd_valid && !seen) begin
        seen = 1'b1;
        hold = rd_data;
      end else if (seen) begin
        chk(rd_valid && rd_data == hold, "R7", "head held while stalled", rd_data, hold);
      end
    end
    chk(n_acc == S + 1, "R6", "capacity with reads stalled", n_acc, S + 1);
    chk(hold == 16'h1000, "R7", "head word while stalled", hold, 16'h1000);

    // R10: writes while not ready are ignored
    acc0 = n_acc;
    for (int k = 0; k < 5; k++) step(1'b1, 16'hDEAD, 1'b0);
    chk(n_acc == acc0 && wr_ready == 1'b0, "R10", "write while full accepted", n_acc, acc0);

    // R5: hole latency through a full pipeline
    step(1'b0, '0, 1'b1);
    seen = 1'b0;
    for (int k = 1; k < hole_edges(S); k++) begin
      step(1'b0, '0, 1'b0);
      if (wr_ready) seen = 1'b1;
    end
    chk(!seen, "R5", "wr_ready early", seen, 0);
    step(1'b0, '0, 1'b0);
    chk(wr_ready == 1'b1, "R5", "wr_ready at STAGES after take", wr_ready, 1);

    // Drain: no ignored word may appear (R10, R3)
    for (int k = 0; k < 40; k++) step(1'b0, '0, 1'b1);
    chk(sb.size() == 0 && rd_valid == 1'b0, "R10", "drain left words", sb.size(), 0);

    // Random traffic in three phases (R3, R8, R9 via word integrity)
    max_occ = 0;
    for (int ph = 0; ph < 3; ph++) begin
      for (int k = 0; k < 1500; k++) begin
        logic wv;
        logic rt;
        case (ph)
          0: begin wv = ($urandom % 8) != 0; rt = ($urandom % 4) == 0; end
          1: begin wv = ($urandom % 4) == 0; rt = ($urandom % 8) != 0; end
          default: begin wv = $urandom % 2; rt = $urandom % 2; end
        endcase
        step(wv, DW'($urandom), rt);
      end
    end
    chk(max_occ <= S + 1, "R6", "occupancy bound in random traffic", max_occ, S + 1);
    for (int k = 0; k < 60; k++) step(1'b0, '0, 1'b1);
    chk(sb.size() == 0, "R3", "R8 R9 words lost in random traffic", sb.size(), 0);
    chk(rd_valid == 1'b0 && wr_ready == 1'b1, "R9", "idle after drain",
        {rd_valid, wr_ready}, 2'b01);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule